// File: doc/BRIEF.md
# Bit-Serial CRC-32 Sender and Checker

This block computes the 32-bit cyclic redundancy check of a bit stream, one bit per clock. The same engine serves a transmitter and a receiver. A transmitter feeds the message and reads the complemented checksum from `crc_out` to append to the frame. A receiver feeds the whole frame, checksum included, and reads a pass flag that compares the final register against the fixed residue of an error-free frame.

The register is 32 bits wide and uses the reflected (right-shifting) form of the generator x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1, whose low 32 bits reflected are 0xEDB88320. Each input bit is combined at the output end of the register, so the register always holds the remainder of the message so far as if 32 zero bits had been appended. No flush bits are needed. A `start` pulse presets the register to all ones. Within each byte the caller presents the least significant bit first.

The bit input is a valid/ready stream. `in_ready` is low during reset and high at all other times, so the engine never applies back-pressure. A bit is taken on any rising edge where both `in_valid` and `in_ready` are high. A source may hold `in_valid` low for any number of cycles mid-frame. `start` and `last` are sideband flags: they have effect only as described in the requirements.

Top module: `serial_crc32`

## Requirements
- R1: While reset is held and on the first cycle after it, the register is all ones, `crc_out` is 0x00000000, and `done` and `crc_ok` are low.
- R2: `in_ready` is low during reset and high in every cycle after the first clock edge out of reset. A bit is accepted when `in_valid` and `in_ready` are both high.
- R3: Each accepted bit updates the register as next = (reg >> 1) XOR (0xEDB88320 if reg[0] XOR bit is 1, else 0). `crc_out` is always the bitwise complement of the register. The bytes of "123456789", each sent least significant bit first, yield `crc_out` = 0xCBF43926.
- R4: A `start` accepted together with a valid bit loads all ones and then processes that bit as the first bit of the new message.
- R5: A `start` with `in_valid` low loads all ones, and the register takes no bit.
- R6: In a cycle with no accepted bit and no `start`, the register and `crc_out` keep their value.
- R7: `done` is high for exactly the one cycle after a bit accepted with `last` high. In that cycle `crc_out` shows the checksum of the frame.
- R8: `crc_ok` is high only when `done` is high and the register equals the residue 0xDEBB20E3 (`crc_out` = 0x2144DF1C). A message followed by its own `crc_out` value, sent bit 0 first, gives `crc_ok` high.
- R9: A frame with any single bit flipped gives `done` high with `crc_ok` low.
- R10: A new frame may start in the cycle right after a last bit. The `done` result of the old frame is unaffected, and the new frame computes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Bit present on `in_bit` |
| in_ready | output | 1 | Engine accepts a bit this cycle |
| in_bit | input | 1 | Serial message bit |
| in_start | input | 1 | Preset register to all ones (first bit of a frame when valid) |
| in_last | input | 1 | Accepted bit is the last of the frame |
| crc_out | output | 32 | Complement of the CRC register |
| done | output | 1 | One-cycle pulse after the last bit |
| crc_ok | output | 1 | Frame matches the error-free residue; valid with `done` |

## Verification
Two functions can fall in the same cycle. The first pair is the preset and the first bit of a frame: the bench raises `in_start` together with a valid bit on every frame, and once for a one-bit frame where `start` and `last` coincide. It then checks the exact register value against a hand-computed step from all ones. The second pair is the `done` report of one frame and the first bit of the next: the bench drives them back to back. It then checks the old frame's `crc_out` and `done` in the same cycle as the new start, and checks the new frame's checksum against its known value.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] POLY_REFL  = 32'hEDB88320;
  localparam logic [CRC_W-1:0] PRESET     = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] OUT_INVERT = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] GOOD_RESID = 32'hDEBB20E3;
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[0] ^ din;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign nxt[i] = POLY[i] & fb;
    end else begin : g_mid
      assign nxt[i] = cur[i+1] ^ (POLY[i] & fb);
    end
  end
endmodule

// File: rtl/crc_shift_reg.sv
module crc_shift_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320,
  parameter logic [W-1:0] INIT = 32'hFFFFFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         preset,
  input  logic         din,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] base;
  logic [W-1:0] stepped;

  assign base = preset ? INIT : state_q;

  crc_bit_step #(.W(W), .POLY(POLY)) u_step (
    .cur(base),
    .din(din),
    .nxt(stepped)
  );

  always_ff @(posedge clk) begin
    if (rst)         state_q <= INIT;
    else if (take)   state_q <= stepped;
    else if (preset) state_q <= INIT;
  end

  assign state_o = state_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!take && !preset) |=> $stable(state_q));

  assert_preset_R5: assert property (@(posedge clk) disable iff (rst)
    (preset && !take) |=> (state_q == INIT));
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RESID = 32'hDEBB20E3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         last,
  input  logic [W-1:0] state,
  output logic         ready,
  output logic         take,
  output logic         done,
  output logic         ok
);
  logic ready_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= valid && ready_q && last;
    end
  end

  assign ready = ready_q;
  assign take  = valid && ready_q;
  assign done  = done_q;
  assign ok    = done_q && (state == RESID);
endmodule

// File: rtl/serial_crc32.sv
module serial_crc32
  import crc32_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL,
  parameter logic [W-1:0] INIT = PRESET,
  parameter logic [W-1:0] XOUT = OUT_INVERT,
  parameter logic [W-1:0] RESID = GOOD_RESID
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bit,
  input  logic         in_start,
  input  logic         in_last,
  output logic [W-1:0] crc_out,
  output logic         done,
  output logic         crc_ok
);
  logic         take;
  logic [W-1:0] state;

  crc_frame_ctrl #(.W(W), .RESID(RESID)) u_ctrl (
    .clk(clk), .rst(rst), .valid(in_valid), .last(in_last),
    .state(state), .ready(in_ready), .take(take), .done(done), .ok(crc_ok)
  );

  crc_shift_reg #(.W(W), .POLY(POLY), .INIT(INIT)) u_reg (
    .clk(clk), .rst(rst), .take(take), .preset(in_start),
    .din(in_bit), .state_o(state)
  );

  assign crc_out = state ^ XOUT;

  assert_ready_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> in_ready);

  assert_done_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> done);

  assert_ok_R8: assert property (@(posedge clk) disable iff (rst)
    crc_ok |-> (done && crc_out == (RESID ^ XOUT)));
endmodule

// File: tb/serial_crc32_tb.sv
module serial_crc32_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int VLEN [NV] = '{1, 3, 1, 4, 4};
  localparam logic [31:0] VDATA [NV] = '{32'h00000061, 32'h00636261,
                                        32'h00000000, 32'h00000000, 32'hFFFFFFFF};
  localparam logic [31:0] VCRC [NV] = '{32'hE8B7BE43, 32'h352441C2,
                                       32'hD202EF8D, 32'h2144DF1C, 32'hFFFFFFFF};
  localparam logic [31:0] GOOD_OUT = 32'h2144DF1C;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_bit = 0, in_start = 0, in_last = 0;
  logic in_ready, done, crc_ok;
  logic [31:0] crc_out;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_crc32 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_start(in_start), .in_last(in_last),
    .crc_out(crc_out), .done(done), .crc_ok(crc_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic s, input logic l);
    @(negedge clk);
    in_valid = v; in_bit = b; in_start = s; in_last = l;
  endtask

  // Sends a frame of nbits from data (bit 0 first), optionally followed by a 32-bit tail.
  // Leaves the last bit driven; caller goes to the next negedge to sample.
  task automatic send(input logic [71:0] data, input int nbits, input logic [31:0] tail,
                      input bit use_tail, input bit gaps);
    int tot;
    tot = nbits + (use_tail ? 32 : 0);
    for (int i = 0; i < tot; i++) begin
      logic b;
      b = (i < nbits) ? data[i] : tail[i - nbits];
      if (gaps && i > 0 && (i % 3 == 0)) begin
        drive(0, ~b, 0, 0);
        drive(0, b, 0, 0);
      end
      drive(1, b, i == 0, i == tot - 1);
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    // R1 / R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 ready low in reset", {31'd0, in_ready}, 0);
    chk("R1 crc_out in reset", crc_out, 32'h0);
    chk("R1 done in reset", {31'd0, done}, 0);
    @(negedge clk); rst = 0;
    chk("R1 crc_out after reset", crc_out, 32'h0);
    chk("R1 crc_ok after reset", {31'd0, crc_ok}, 0);
    @(negedge clk);
    chk("R2 ready after reset", {31'd0, in_ready}, 1);

    // Vector table: send, receive, corrupted receive
    for (int k = 0; k < NV; k++) begin
      send({40'd0, VDATA[k]}, VLEN[k] * 8, 32'd0, 0, k % 2 == 1);
      idle();
      chk($sformatf("R3 R7 crc vec%0d", k), crc_out, VCRC[k]);
      chk($sformatf("R7 done vec%0d", k), {31'd0, done}, 1);
      got = crc_out;
      idle();
      chk($sformatf("R7 done one cycle vec%0d", k), {31'd0, done}, 0);
      chk($sformatf("R6 crc held vec%0d", k), crc_out, got);
      send({40'd0, VDATA[k]}, VLEN[k] * 8, VCRC[k], 1, k % 2 == 0);
      idle();
      chk($sformatf("R8 ok vec%0d", k), {31'd0, crc_ok}, 1);
      chk($sformatf("R8 residue vec%0d", k), crc_out, GOOD_OUT);
      send({40'd0, VDATA[k] ^ 32'h4}, VLEN[k] * 8, VCRC[k], 1, 0);
      idle();
      chk($sformatf("R9 done corrupt vec%0d", k), {31'd0, done}, 1);
      chk($sformatf("R9 not ok vec%0d", k), {31'd0, crc_ok}, 0);
    end

    // R3: nine-byte check string "123456789"
    send(72'h393837363534333231, 72, 32'd0, 0, 0);
    idle();
    chk("R3 check string", crc_out, 32'hCBF43926);

    // R4: one-bit frames with start, valid and last together
    drive(1, 1, 1, 1); idle();
    chk("R4 one-bit frame bit1", crc_out, 32'h80000000);
    chk("R4 one-bit frame done", {31'd0, done}, 1);
    drive(1, 0, 1, 1); idle();
    chk("R4 one-bit frame bit0", crc_out, 32'h6DB88320);

    // R5: garbage bits, start alone, then "a" without start
    drive(1, 1, 0, 0); drive(1, 0, 0, 0); drive(1, 1, 0, 0);
    drive(0, 1, 1, 0); idle();
    chk("R5 start alone loads ones", crc_out, 32'h0);
    for (int i = 0; i < 8; i++) drive(1, VDATA[0][i], 0, i == 7);
    idle();
    chk("R5 message after bare start", crc_out, VCRC[0]);

    // R10: back-to-back frames, "a" then "abc"
    send({40'd0, VDATA[0]}, 8, 32'd0, 0, 0);
    drive(1, VDATA[1][0], 1, 0);
    chk("R10 old frame done at new start", {31'd0, done}, 1);
    chk("R10 old frame crc at new start", crc_out, VCRC[0]);
    for (int i = 1; i < 24; i++) drive(1, VDATA[1][i], 0, i == 23);
    idle();
    chk("R10 new frame crc", crc_out, VCRC[1]);

    // R1: reset mid-frame returns to preset
    drive(1, 1, 1, 0); drive(1, 0, 0, 0);
    @(negedge clk); in_valid = 0; rst = 1;
    @(negedge clk);
    chk("R1 reset mid-frame crc_out", crc_out, 32'h0);
    chk("R1 reset mid-frame done", {31'd0, done}, 0);
    rst = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule